// File: doc/BRIEF.md
# Systolic Cascaded FIR Filter

This block is a finite impulse response filter made from a chain of identical multiply-accumulate stages in systolic form. Each stage multiplies its own fixed coefficient by a data sample and adds the product to an addend that arrives from the stage before it. Two separate paths link neighbouring stages. The sample path passes the input data from stage to stage, and each stage delays it by its own data registers. The sum path passes the registered partial sum forward. The first stage takes the external sample as its data and a constant bias as its addend. The filtered result is the registered sum of the last stage.

Coefficients and bias are inputs that must be set before reset is released and held steady while the filter runs. A clock enable stalls the whole pipeline. A synchronous reset empties it. Samples are 18-bit signed, coefficients are 27-bit signed, and the sum path is 48-bit two's complement that wraps on overflow. The tap count is a parameter.

Top module: `cascade_fir`

## Requirements
- R1: A synchronous reset clears every data, product and sum register, and reset takes priority over `en`. The output reads 0 on the cycle after any reset edge.
- R2: Count enabled non-reset edges since the last reset as k = 1, 2, and so on. Let x(t) be the sample taken at the t-th such edge, with x(t) = 0 for t < 1. After edge k the output equals B(k) + Σ_j c_j·x(k−N−1−j), where N is the tap count, j runs from 0 to N−1, and B(k) is the bias when k ≥ N and 0 otherwise.
- R3: The first stage holds one data register. Every later stage holds two in series, and its cascade data output is taken after them. A sample therefore first affects the output N+1 enabled edges after it is taken.
- R4: The bias enters only the first stage's adder. With zero input it reaches the output at enabled edge N after reset and not before.
- R5: While `en` is low and reset is not asserted, no register changes. The output holds, and a sample presented in that cycle has no effect.
- R6: Sums are 48-bit two's complement and wrap modulo 2^48. Samples and coefficients are signed.
- R7: A single unit impulse produces bias + c_0, bias + c_1, … bias + c_{N−1} at consecutive enabled edges, in tap order.
- R8: The tap count N is a parameter. Coefficient j occupies bits [27·j +: 27] of `coefIn`, and N = 4 with coefficients 1, 12, 3, 4 is a valid configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for every pipeline register |
| sampleIn | input | 18 | Signed input sample |
| coefIn | input | 27·TAPS | Packed signed coefficients, tap j at bits [27·j +: 27] |
| biasIn | input | 48 | Signed constant added in the first stage |
| sampleOut | output | 48 | Signed filtered output, the last stage's sum |

## Verification
The cascade assertions assume that `coefIn` and `biasIn` change only while reset is asserted. Under that assumption, the coefficient registers loaded at reset match the live port values. The stimulus follows this rule: every new coefficient or bias set is applied between two reset edges. The assertions also look back only across edges that advanced. Stalled stretches come from a random enable pattern, and the bench checks a held output on every stalled cycle.

// File: rtl/cascade_fir_pkg.sv
package cascade_fir_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // synchronous clear of the pipeline
    logic advance;  // every register loads this cycle
  } firStrobes_t;

endpackage

// File: rtl/cascade_fir_ctrl.sv
module cascade_fir_ctrl
  import cascade_fir_pkg::*;
(
  input  logic        rst,
  input  logic        en,
  output firStrobes_t strb
);

  // Reset wins over enable (R1); enable low stalls everything (R5)
  always_comb begin
    strb.clear   = rst;
    strb.advance = en & ~rst;
  end

endmodule

// File: rtl/cascade_fir_stage.sv
module cascade_fir_stage
  import cascade_fir_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int COEF_W = 27,
  parameter int SUM_W  = 48,
  parameter bit FIRST  = 1'b0
) (
  input  logic                     clk,
  input  firStrobes_t              strb,
  input  logic signed [COEF_W-1:0] coefIn,
  input  logic signed [DATA_W-1:0] dataIn,
  input  logic signed [SUM_W-1:0]  addIn,
  output logic signed [DATA_W-1:0] dataOut,
  output logic signed [SUM_W-1:0]  sumOut
);

  localparam int PROD_W = DATA_W + COEF_W;
  localparam int DEPTH  = FIRST ? 1 : 2;   // R3: data registers per stage

  logic signed [DATA_W-1:0] dataPipe [DEPTH];
  logic signed [COEF_W-1:0] coefReg;
  logic signed [PROD_W-1:0] prodReg;
  logic signed [SUM_W-1:0]  sumReg;
  logic signed [SUM_W-1:0]  prodExt;

  for (genvar d = 0; d < DEPTH; d++) begin : g_data
    if (d == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (strb.clear)        dataPipe[d] <= '0;
        else if (strb.advance) dataPipe[d] <= dataIn;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (strb.clear)        dataPipe[d] <= '0;
        else if (strb.advance) dataPipe[d] <= dataPipe[d-1];
      end
    end
  end

  assign dataOut = dataPipe[DEPTH-1];
  assign prodExt = SUM_W'(prodReg);

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      coefReg <= coefIn;
      prodReg <= '0;
      sumReg  <= '0;
    end else if (strb.advance) begin
      coefReg <= coefIn;
      prodReg <= PROD_W'(coefReg) * PROD_W'(dataOut);
      sumReg  <= addIn + prodExt;   // R6: wraps modulo 2^SUM_W
    end
  end

  assign sumOut = sumReg;

endmodule

// File: rtl/cascade_fir_dp.sv
module cascade_fir_dp
  import cascade_fir_pkg::*;
#(
  parameter int TAPS   = 4,
  parameter int DATA_W = 18,
  parameter int COEF_W = 27,
  parameter int SUM_W  = 48
) (
  input  logic                      clk,
  input  firStrobes_t               strb,
  input  logic signed [DATA_W-1:0]  sampleIn,
  input  logic [TAPS*COEF_W-1:0]    coefIn,
  input  logic signed [SUM_W-1:0]   biasIn,
  output logic signed [SUM_W-1:0]   sumLast
);

  logic signed [COEF_W-1:0] coefTap   [TAPS];
  logic signed [DATA_W-1:0] dataChain [TAPS];
  logic signed [SUM_W-1:0]  sumChain  [TAPS];
  logic signed [SUM_W-1:0]  addChain  [TAPS];

  function automatic logic signed [SUM_W-1:0] macRef(
    input logic signed [SUM_W-1:0]  a,
    input logic signed [COEF_W-1:0] c,
    input logic signed [DATA_W-1:0] d
  );
    return a + SUM_W'(c) * SUM_W'(d);
  endfunction

  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    assign coefTap[j] = coefIn[j*COEF_W +: COEF_W];   // R8 packing

    if (j == 0) begin : g_first
      assign addChain[j] = biasIn;                    // R4
      cascade_fir_stage #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .SUM_W(SUM_W), .FIRST(1'b1)
      ) u_stage (
        .clk(clk), .strb(strb), .coefIn(coefTap[j]), .dataIn(sampleIn),
        .addIn(addChain[j]), .dataOut(dataChain[j]), .sumOut(sumChain[j])
      );
    end else begin : g_rest
      assign addChain[j] = sumChain[j-1];
      cascade_fir_stage #(
        .DATA_W(DATA_W), .COEF_W(COEF_W), .SUM_W(SUM_W), .FIRST(1'b0)
      ) u_stage (
        .clk(clk), .strb(strb), .coefIn(coefTap[j]), .dataIn(dataChain[j-1]),
        .addIn(addChain[j]), .dataOut(dataChain[j]), .sumOut(sumChain[j])
      );

      // R3: two data registers between neighbouring cascade outputs
      a_r3_data_cascade: assert property (@(posedge clk) disable iff (strb.clear)
        ($past(strb.advance, 1) && $past(strb.advance, 2))
          |-> dataChain[j] == $past(dataChain[j-1], 2));
    end

    // R2: each stage adds its delayed product to the incoming addend
    a_r2_sum_cascade: assert property (@(posedge clk) disable iff (strb.clear)
      ($past(strb.advance, 1) && $past(strb.advance, 2))
        |-> sumChain[j] == macRef($past(addChain[j]), coefTap[j],
                                  $past(dataChain[j], 2)));
  end

  assign sumLast = sumChain[TAPS-1];

endmodule

// File: rtl/cascade_fir.sv
module cascade_fir
  import cascade_fir_pkg::*;
#(
  parameter int TAPS   = 4,
  parameter int DATA_W = 18,
  parameter int COEF_W = 27,
  parameter int SUM_W  = 48
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic [TAPS*COEF_W-1:0]   coefIn,
  input  logic signed [SUM_W-1:0]  biasIn,
  output logic signed [SUM_W-1:0]  sampleOut
);

  firStrobes_t strb;

  cascade_fir_ctrl u_ctrl (
    .rst(rst), .en(en), .strb(strb)
  );

  cascade_fir_dp #(
    .TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .SUM_W(SUM_W)
  ) u_dp (
    .clk(clk), .strb(strb), .sampleIn(sampleIn), .coefIn(coefIn),
    .biasIn(biasIn), .sumLast(sampleOut)
  );

  logic rstDly;
  always_ff @(posedge clk) rstDly <= rst;

  // R1: output reads zero right after reset
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    rstDly |-> sampleOut == '0);

  // R5: a stalled cycle leaves the output untouched
  a_r5_hold_output: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sampleOut));

endmodule

// File: tb/cascade_fir_test.sv
`timescale 1ns/1ps
module cascade_fir_test;
  localparam int TAPS = 4;
  localparam int DW   = 18;
  localparam int CW   = 27;
  localparam int SW   = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [DW-1:0]  sampleIn = '0;
  logic [TAPS*CW-1:0]    coefIn   = '0;
  logic signed [SW-1:0]  biasIn   = '0;
  logic signed [SW-1:0]  sampleOut;

  int errors = 0;
  int checks = 0;
  longint coefM [TAPS];
  longint biasM;
  longint hist [$];
  int k = 0;

  always #4 clk = ~clk;   // 125 MHz

  cascade_fir #(.TAPS(TAPS), .DATA_W(DW), .COEF_W(CW), .SUM_W(SW)) uut (
    .clk(clk), .rst(rst), .en(en), .sampleIn(sampleIn), .coefIn(coefIn),
    .biasIn(biasIn), .sampleOut(sampleOut)
  );

  function automatic longint wrapSum(input longint v);
    return (v <<< 16) >>> 16;
  endfunction

  function automatic longint modelOut();
    longint r = (k >= TAPS) ? biasM : 0;
    for (int j = 0; j < TAPS; j++) begin
      int idx = k - TAPS - 1 - j;
      if (idx >= 1) r += coefM[j] * hist[idx-1];
    end
    return wrapSum(r);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Must be called only while rst is high (coefficient rule)
  task automatic loadCfg(input longint c0, input longint c1, input longint c2,
                         input longint c3, input longint b);
    coefM[0] = c0; coefM[1] = c1; coefM[2] = c2; coefM[3] = c3;
    for (int j = 0; j < TAPS; j++) coefIn[j*CW +: CW] = CW'(coefM[j]);
    biasM  = b;
    biasIn = SW'(b);
  endtask

  task automatic tick(input bit r, input bit e, input longint s,
                      input string tag);
    longint prev, exp, act;
    @(negedge clk);
    rst = r; en = e; sampleIn = DW'(s);
    prev = longint'(sampleOut);
    @(posedge clk);
    if (r) begin
      k = 0;
      hist.delete();
    end else if (e) begin
      k++;
      hist.push_back(longint'(sampleIn));
    end
    #1;
    exp = modelOut();
    act = longint'(sampleOut);
    check(act == exp, tag, act, exp);
    if (!r && !e) check(act == prev, "R5 stalled output held", act, prev);
  endtask

  function automatic longint rndSample();
    return longint'($urandom_range(0, 262143)) - 131072;
  endfunction

  initial begin
    #160000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint expv;
    loadCfg(1, 12, 3, 4, 100);
    for (int i = 0; i < 3; i++) tick(1, 0, 0, "R1 reset state");
    check(sampleOut == 0, "R1 output zero in reset", sampleOut, 0);

    // Bias arrival with zero input
    for (int i = 1; i <= TAPS + 1; i++) begin
      tick(0, 1, 0, (i < TAPS) ? "R4 bias not yet at output" : "R4 bias at output");
      if (i == TAPS - 1) check(sampleOut == 0, "R4 before edge N", sampleOut, 0);
      if (i == TAPS) check(sampleOut == 100, "R4 at edge N", sampleOut, 100);
    end

    // Impulse: latency and tap order
    tick(0, 1, 1, "R3 impulse taken");
    for (int i = 1; i <= TAPS + 6; i++) begin
      tick(0, 1, 0, "R7 R8 impulse response");
      if (i == TAPS)     check(sampleOut == 100, "R3 no response before N+1", sampleOut, 100);
      if (i >= TAPS + 1 && i <= 2*TAPS) begin
        expv = 100 + coefM[i-TAPS-1];
        check(sampleOut == expv, "R7 tap order", sampleOut, expv);
      end
    end

    // Constant input
    for (int i = 0; i < 12; i++) tick(0, 1, 5, "R2 constant input");
    check(sampleOut == 100 + 5*20, "R2 constant steady state", sampleOut, 200);

    // Random enable pattern
    for (int i = 0; i < 60; i++)
      tick(0, ($urandom_range(0, 2) != 0), rndSample(), "R5 enable gaps");

    // Random samples
    for (int i = 0; i < 200; i++) tick(0, 1, rndSample(), "R2 random samples");

    // Reset while enable low, new extreme configuration
    tick(1, 0, 7, "R1 mid-run reset");
    loadCfg(-(64'sd1 <<< 26), (64'sd1 <<< 26) - 1, -1, 12345, -(64'sd1 <<< 40));
    tick(1, 1, 9, "R1 reset beats enable");
    check(sampleOut == 0, "R1 reset beats enable", sampleOut, 0);
    for (int i = 0; i < 100; i++) begin
      longint s = rndSample();
      if (i % 7 == 0) s = -131072;
      if (i % 7 == 3) s = 131071;
      tick(0, 1, s, "R6 signed extremes");
    end

    // Wrap-around of the 48-bit sum
    tick(1, 0, 0, "R1 reset");
    loadCfg((64'sd1 <<< 26) - 1, (64'sd1 <<< 26) - 1, (64'sd1 <<< 26) - 1,
            (64'sd1 <<< 26) - 1, (64'sd1 <<< 47) - 1);
    tick(1, 0, 0, "R1 reset");
    for (int i = 0; i < 12; i++) tick(0, 1, 131071, "R6 wrap");
    expv = wrapSum(((64'sd1 <<< 47) - 1) + 4 * (((64'sd1 <<< 26) - 1) * 131071));
    check(sampleOut == expv, "R6 wrapped sum", sampleOut, expv);
    check(sampleOut < 0, "R6 wrap gives negative", sampleOut, expv);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule